// File: doc/BRIEF.md
# RTC Alarm Comparator and Interrupt Registers

This block sits beside a real-time clock's seconds counter. Each seconds strobe raises a seconds event flag. If the running seconds value equals a programmed alarm time on that strobe, it also raises an alarm event flag. Software reads and clears the flags through a small word-addressed register port. It gates each flag onto its own interrupt line through an enable state, which has separate write-one set and write-one clear registers and one read-only view.

Flags are sticky. A masked source still records its event, so enabling it later raises the interrupt at once if the flag is still set. The alarm register keeps its value until it is written again, so software that restarts finds the alarm it left behind.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset both event flags are 0, both enables are 0, the alarm register is 0, and both interrupt outputs are low.
- R2: A cycle with `sec_tick` high sets event flag bit 0 (seconds) on that clock edge.
- R3: A cycle with `sec_tick` high and `cur_sec` equal to the alarm register sets event flag bit 1 (alarm). Without a strobe, or when the values differ, bit 1 does not set.
- R4: Writing the flags register (word address 8) clears each flag whose `wdata` bit is 1 (bit 0 seconds, bit 1 alarm). A 0 bit leaves the flag unchanged, and flags hold their value when neither a set nor a clear applies.
- R5: When a set and a write-one clear reach the same flag in the same cycle, the flag ends set.
- R6: Writing 1 to bit n of the enable-set register (word address 10) enables source n. Writing 0 to a bit leaves it unchanged.
- R7: Writing 1 to bit n of the enable-clear register (word address 11) masks source n. Writing 0 to a bit leaves it unchanged.
- R8: Reading the enable-view register (word address 9) returns the enable states in bits [1:0] (1 = enabled), with the upper bits 0. Writes to it have no effect.
- R9: `sec_irq` equals flag bit 0 AND enable bit 0, and `alarm_irq` equals flag bit 1 AND enable bit 1, with no added cycle. Masking a source does not clear its flag.
- R10: The alarm register (word address 6) takes `wdata[TIME_W-1:0]` on a write and reads it back zero-extended. No other write or event changes it.
- R11: Reads of the flags register return the flags in bits [1:0]. Reads of the enable-set, enable-clear and unmapped addresses return 0. Writes to unmapped addresses change no state. `rdata` follows `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe when the seconds count advances |
| cur_sec | input | TIME_W | Current seconds value |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| alarm_irq | output | 1 | Alarm interrupt, level |
| sec_irq | output | 1 | Seconds interrupt, level |

## Verification
The bench builds the block with a 4-bit `TIME_W`, which makes the alarm comparator small enough to cover completely. Every pair of alarm value and current seconds value (256 pairs) is struck with a strobe, and the resulting alarm flag is compared with the arithmetic equality. The same small build lets the bench sweep every combination of flag state, enable state and clear pattern, including a set that collides with a clear in the same cycle.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int TIME_W = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_ALARM = 6,
  parameter logic [ADDR_W-1:0] A_FLAGS = 8,
  parameter logic [ADDR_W-1:0] A_VIEW  = 9,
  parameter logic [ADDR_W-1:0] A_ON    = 10,
  parameter logic [ADDR_W-1:0] A_OFF   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [TIME_W-1:0] cur_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              alarm_irq,
  output logic              sec_irq
);
  localparam int NSRC = 2;

  logic [TIME_W-1:0] alarm_q;
  logic [NSRC-1:0]   flag_q, en_q, set_v, clr_v;

  assign set_v = {sec_tick && (cur_sec == alarm_q), sec_tick};
  assign clr_v = (wr_en && addr == A_FLAGS) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (wr_en && addr == A_ON)  en_q <= en_q | wdata[NSRC-1:0];
    else if (wr_en && addr == A_OFF) en_q <= en_q & ~wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alarm_q <= '0;
    else if (wr_en && addr == A_ALARM) alarm_q <= wdata[TIME_W-1:0];

  always_comb begin
    rdata = '0;
    if (addr == A_ALARM)      rdata = DATA_W'(alarm_q);
    else if (addr == A_FLAGS) rdata = DATA_W'(flag_q);
    else if (addr == A_VIEW)  rdata = DATA_W'(en_q);
  end

  assign sec_irq   = flag_q[0] & en_q[0];
  assign alarm_irq = flag_q[1] & en_q[1];
endmodule

module rtc_alarm_irq_chk #(
  parameter int TIME_W = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_ALARM = 6,
  parameter logic [ADDR_W-1:0] A_FLAGS = 8,
  parameter logic [ADDR_W-1:0] A_ON    = 10,
  parameter logic [ADDR_W-1:0] A_OFF   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic [TIME_W-1:0] cur_sec,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [TIME_W-1:0] alarm_q,
  input logic [1:0]        flag_q,
  input logic [1:0]        en_q,
  input logic              alarm_irq,
  input logic              sec_irq
);
  // R2
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> flag_q[0]);
  // R3
  alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && cur_sec == alarm_q) |=> flag_q[1]);
  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(wr_en && addr == A_FLAGS)) |=> $stable(flag_q));
  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAGS && wdata[0] && !sec_tick) |=> !flag_q[0]);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAGS && wdata[0] && sec_tick) |=> flag_q[0]);
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ON && wdata[1]) |=> en_q[1]);
  // R7
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OFF && wdata[1]) |=> !en_q[1]);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] |-> !alarm_irq) and (!en_q[0] |-> !sec_irq));
  // R10
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_ALARM) |=> $stable(alarm_q));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
  .TIME_W(TIME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .A_ALARM(A_ALARM), .A_FLAGS(A_FLAGS), .A_ON(A_ON), .A_OFF(A_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .alarm_q(alarm_q),
  .flag_q(flag_q), .en_q(en_q), .alarm_irq(alarm_irq), .sec_irq(sec_irq)
);

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;
  localparam int TW = 4;
  logic clk = 0, rst_n = 0, sec_tick = 0, wr_en = 0;
  logic [TW-1:0] cur_sec = '0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic alarm_irq, sec_irq;
  int runs = 0, fails = 0;
  bit done = 0;

  rtc_alarm_irq #(.TIME_W(TW)) i_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_irq(alarm_irq), .sec_irq(sec_irq));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    wr_en = 0; addr = a; #1 d = rdata;
  endtask

  task automatic tick(logic [TW-1:0] c);
    @(negedge clk); sec_tick = 1; cur_sec = c;
    @(negedge clk); sec_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(8, rv); chk("R1 flags", rv, 0);
    rd(9, rv); chk("R1 enables", rv, 0);
    rd(6, rv); chk("R1 alarm", rv, 0);
    chk("R1 irqs", {alarm_irq, sec_irq}, 0);

    // R3 exhaustive compare sweep, R2 seconds flag
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < 16; c++) begin
        wr(6, 32'hFFFF_FFF0 | a);
        wr(8, 3);
        tick(c[TW-1:0]);
        rd(8, rv);
        chk("R2/R3 flags after tick", rv, {30'd0, a == c, 1'b1});
      end

    // R10 readback, other writes leave it alone
    wr(6, 32'h0000_0009);
    rd(6, rv); chk("R10 alarm readback", rv, 9);
    wr(8, 3); wr(10, 3); wr(11, 3); wr(9, 3); wr(3, 32'hF);
    rd(6, rv); chk("R10 alarm unchanged", rv, 9);

    // R3 no set without strobe
    wr(8, 3);
    @(negedge clk); cur_sec = 9; @(negedge clk);
    rd(8, rv); chk("R3 no strobe no set", rv, 0);

    // R4 write-one-clear sweep over patterns
    for (int p = 0; p < 4; p++) begin
      tick(9); rd(8, rv); chk("R4 setup", rv, 3);
      wr(8, p);
      rd(8, rv); chk("R4 w1c", rv, 3 & ~p);
      wr(8, 3);
    end

    // R5 set beats clear
    @(negedge clk); wr_en = 1; addr = 8; wdata = 3; sec_tick = 1; cur_sec = 9;
    @(negedge clk); wr_en = 0; sec_tick = 0;
    rd(8, rv); chk("R5 set wins", rv, 3);

    // R6 R7 R8 enable sweep
    wr(11, 3);
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        wr(11, 3); wr(10, s);
        wr(10, d); rd(9, rv); chk("R6 enable set", rv, s | d);
        wr(11, d); rd(9, rv); chk("R7 enable clear", rv, (s | d) & ~d);
      end
    end
    wr(11, 3); wr(10, 1); wr(9, 2);
    rd(9, rv); chk("R8 view ignores writes", rv, 1);

    // R9 irq gating across all flag/enable states
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 4; e++) begin
        wr(11, 3); wr(8, 3);
        if (f != 0) begin
          wr(6, (f[1]) ? 32'd5 : 32'd6);
          tick(5);
          wr(8, ~f & 3);
        end
        wr(10, e);
        #1 chk("R9 irq gating", {alarm_irq, sec_irq}, f & e);
      end

    // R9 masked event kept, irq on re-enable
    wr(11, 3); wr(8, 3); wr(6, 2);
    tick(2);
    chk("R9 masked irq low", {alarm_irq, sec_irq}, 0);
    rd(8, rv); chk("R9 masked flag kept", rv, 3);
    wr(10, 2); #1 chk("R9 irq on enable", {alarm_irq, sec_irq}, 2'b10);

    // R11 unmapped and write-only reads, unmapped writes
    rd(10, rv); chk("R11 enable-set reads 0", rv, 0);
    rd(11, rv); chk("R11 enable-clear reads 0", rv, 0);
    rd(0, rv);  chk("R11 unmapped reads 0", rv, 0);
    wr(7, 32'hFFFF); wr(15, 32'hFFFF);
    rd(8, rv); chk("R11 flags after unmapped writes", rv, 3);
    rd(9, rv); chk("R11 enables after unmapped writes", rv, 2);
    rd(6, rv); chk("R11 alarm after unmapped writes", rv, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule